// File: doc/BRIEF.md
# Peripheral Clock Stop Handshake Controller

This block gates the clocks of on-chip peripherals. Some of them master a bus: an external memory controller, a USB function and a UART. For these, software does not cut the clock directly. It sets a stop-request bit for the peripheral, and the block forwards the request. The clock enable falls only after the peripheral answers with an acknowledge, which arrives asynchronously and is synchronised first. A transfer that is in progress therefore completes before its clock disappears. Clearing the request turns the clock back on at once and withdraws the request. Peripherals without a handshake have plain gate bits that switch their clock enable immediately.

Software reaches the block through a small register port with two words. The handshake word holds one request/acknowledge bit pair per bus-master peripheral, with the request in the even bit and the acknowledge in the odd bit above it. The gate word holds one clock-disable bit per peripheral. Its low bits belong to the handshake peripherals and its upper bits to the simple ones. A handshake peripheral whose gate bit already holds its clock off needs no handshake: a request to it is granted internally.

Top module: `clkstop_ctrl`

## Requirements
- R1: After reset every request and gate bit is 0, both read words are 0, every clock enable is 1 and every stop-request output is 0.
- R2: Writing 1 to request bit 2*i of the handshake word (wr_sel = 0) raises periph_stop_req_o[i] two clocks after the write cycle, while hs_clk_en_o[i] stays 1.
- R3: hs_clk_en_o[i] never falls while the synchronised acknowledge is low. It falls on the clock after the synchronised acknowledge is seen, which is three clocks after periph_ack_i[i] rises.
- R4: Once peripheral i is stopped, acknowledge bit 2*i+1 of the handshake word reads 1 (peripheral 0 is the memory controller: request bit 0, acknowledge bit 1).
- R5: Clearing a request bit returns hs_clk_en_o[i] to 1 and drops periph_stop_req_o[i] and the acknowledge read bit on the first clock after the write.
- R6: A request withdrawn before any acknowledge ends the handshake, and the clock is never interrupted.
- R7: A request made while gate bit i already disables handshake peripheral i is granted without raising periph_stop_req_o[i]. The acknowledge read bit becomes 1 and the clock stays off until the request is cleared, even if the gate bit is cleared first.
- R8: Gate bit NUM_HS+j of the gate word (wr_sel = 1) sets sg_clk_en_o[j] to its inverse on the first clock after the write.
- R9: Writes to the acknowledge bit positions have no effect; an acknowledge without a request does not stop the clock.
- R10: An acknowledge that is already high when the request is made still requires a request; the clock then falls three clocks after the write.
- R11: Handshakes of different peripherals run independently and may overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 handshake word, 1 gate word |
| wr_data | input | REG_W | Write data |
| rd_sel | input | 1 | Read target: 0 handshake word, 1 gate word |
| rd_data | output | REG_W | Read data of the selected word |
| periph_ack_i | input | NUM_HS | Asynchronous stop acknowledges from the bus-master peripherals |
| periph_stop_req_o | output | NUM_HS | Stop requests to the bus-master peripherals |
| hs_clk_en_o | output | NUM_HS | Clock enables of the handshake peripherals |
| sg_clk_en_o | output | NUM_SG | Clock enables of the simple peripherals |

## Verification
The hardest case to reach from the ports is the one where a request meets a clock that its gate bit already holds off. In that case no external handshake may take place, and the clock must stay off after the gate bit is removed. The stimulus sets the UART gate bit and then raises its request. It then clears the gate bit while the request is still held, and checks the stop-request output, the acknowledge read bit and the enable at each step. Separate sequences cover an acknowledge that arrives early, a request that is withdrawn before its acknowledge, and overlapping handshakes. They also place acknowledge edges at exact cycles to show that the enable holds for two clocks and falls on the third.

// File: rtl/clkstop_pkg.sv
// Package: shared types and register selectors of the clock stop controller.
// Assumes: nothing beyond IEEE 1800-2017.
package clkstop_pkg;

    // Handshake state of one bus-master peripheral
    typedef enum logic [1:0] {
        HS_RUN  = 2'd0,
        HS_WAIT = 2'd1,
        HS_STOP = 2'd2
    } hs_state_t;

    localparam logic SEL_HS   = 1'b0;
    localparam logic SEL_GATE = 1'b1;

endpackage

// File: rtl/clkstop_sync.sv
// Module: clkstop_sync
// Purpose: brings one asynchronous level into the clk domain through a
// chain of flops.
// Assumes: the input level is stable for longer than STAGES clocks; reset
// clears the chain.
module clkstop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    // Shift the sampled level through the chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/clkstop_hs_fsm.sv
// Module: clkstop_hs_fsm
// Purpose: stop handshake of one bus-master peripheral. It forwards the
// software request, waits for the synchronised acknowledge and only then
// removes the clock. It bypasses the handshake when the gate bit already
// holds the clock off.
// Assumes: req_i and gate_i are register outputs and ack_sync_i is already
// synchronised to clk.
module clkstop_hs_fsm
    import clkstop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic gate_i,
    input  logic ack_sync_i,
    output logic clk_en_o,
    output logic stop_req_o,
    output logic stopped_o
);
    hs_state_t state_q;
    logic      bypass_q;

    // Handshake sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= HS_RUN;
            bypass_q <= 1'b0;
        end else begin
            unique case (state_q)
                HS_RUN: if (req_i) begin
                    state_q  <= gate_i ? HS_STOP : HS_WAIT;
                    bypass_q <= gate_i;
                end
                HS_WAIT: begin
                    if (!req_i)          state_q <= HS_RUN;
                    else if (ack_sync_i) state_q <= HS_STOP;
                end
                HS_STOP: if (!req_i) state_q <= HS_RUN;
                default: state_q <= HS_RUN;
            endcase
        end
    end

    // Outputs: clearing the request releases the clock combinationally
    always_comb begin
        stopped_o  = (state_q == HS_STOP) && req_i;
        clk_en_o   = !gate_i && !stopped_o;
        stop_req_o = req_i && ((state_q == HS_WAIT) ||
                               ((state_q == HS_STOP) && !bypass_q));
    end

    AST_NO_EARLY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_o && !ack_sync_i && state_q != HS_STOP) |=> (clk_en_o || gate_i)); // R3
    AST_STOP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_WAIT && req_i && ack_sync_i) |=> (!clk_en_o || !req_i)); // R3
    AST_BYPASS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_RUN && req_i && gate_i) |=> !stop_req_o); // R7
    AST_RELEASE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_i) |-> (!stop_req_o && !stopped_o)); // R5
endmodule

// File: rtl/clkstop_ctrl.sv
// Module: clkstop_ctrl (top)
// Purpose: holds the request and gate registers, synchronises the peripheral
// acknowledges, runs one handshake per bus-master peripheral and drives all
// clock enables.
// Assumes: 2*NUM_HS <= REG_W and NUM_HS+NUM_SG <= REG_W; SYNC_STAGES >= 2.
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int NUM_HS      = 3,
    parameter int NUM_SG      = 4,
    parameter int REG_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_sel,
    output logic [REG_W-1:0]  rd_data,
    input  logic [NUM_HS-1:0] periph_ack_i,
    output logic [NUM_HS-1:0] periph_stop_req_o,
    output logic [NUM_HS-1:0] hs_clk_en_o,
    output logic [NUM_SG-1:0] sg_clk_en_o
);
    localparam int GATE_W = NUM_HS + NUM_SG;

    logic [NUM_HS-1:0] req_q;
    logic [GATE_W-1:0] gate_q;
    logic [NUM_HS-1:0] ack_sync;
    logic [NUM_HS-1:0] stopped;
    logic [REG_W-1:0]  hs_word;
    logic              unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    // Software-visible request and gate registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            gate_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_HS) begin
                for (int i = 0; i < NUM_HS; i++) req_q[i] <= wr_data[2*i];
            end else begin
                gate_q <= wr_data[GATE_W-1:0];
            end
        end
    end

    for (genvar g = 0; g < NUM_HS; g++) begin : g_hs
        clkstop_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (periph_ack_i[g]),
            .q     (ack_sync[g])
        );
        clkstop_hs_fsm u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_i      (req_q[g]),
            .gate_i     (gate_q[g]),
            .ack_sync_i (ack_sync[g]),
            .clk_en_o   (hs_clk_en_o[g]),
            .stop_req_o (periph_stop_req_o[g]),
            .stopped_o  (stopped[g])
        );
    end

    // Simple peripherals: enable is the inverse of the gate bit
    assign sg_clk_en_o = ~gate_q[GATE_W-1:NUM_HS];

    // Handshake word: request in even bits, acknowledge in odd bits
    always_comb begin
        hs_word = '0;
        for (int i = 0; i < NUM_HS; i++) begin
            hs_word[2*i]   = req_q[i];
            hs_word[2*i+1] = stopped[i];
        end
    end

    // Read multiplexer
    always_comb begin
        rd_data = '0;
        if (rd_sel == SEL_HS) rd_data = hs_word;
        else                  rd_data[GATE_W-1:0] = gate_q;
    end

    AST_SIMPLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && wr_sel == SEL_GATE) |->
            (sg_clk_en_o == ~$past(wr_data[GATE_W-1:NUM_HS]))); // R8
    AST_STOP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((periph_stop_req_o | stopped) & ~req_q) == '0); // R9
endmodule

// File: tb/clkstop_ctrl_tb.sv
module clkstop_ctrl_tb;
    localparam int NUM_HS = 3;
    localparam int NUM_SG = 4;
    localparam int REG_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              wr_sel = 1'b0;
    logic [REG_W-1:0]  wr_data = '0;
    logic              rd_sel = 1'b0;
    logic [REG_W-1:0]  rd_data;
    logic [NUM_HS-1:0] periph_ack_i = '0;
    logic [NUM_HS-1:0] periph_stop_req_o;
    logic [NUM_HS-1:0] hs_clk_en_o;
    logic [NUM_SG-1:0] sg_clk_en_o;

    clkstop_ctrl #(.NUM_HS(NUM_HS), .NUM_SG(NUM_SG), .REG_W(REG_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .periph_ack_i(periph_ack_i), .periph_stop_req_o(periph_stop_req_o),
        .hs_clk_en_o(hs_clk_en_o), .sg_clk_en_o(sg_clk_en_o)
    );

    always #4 clk = ~clk;   // 125 MHz

    // kinds: 0 hs enables, 1 stop requests, 2 simple enables, 3 handshake word, 4 gate word
    typedef struct {
        int          cyc;
        int          kind;
        logic [15:0] val;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    task automatic push(int d, int kind, logic [15:0] val, string tag);
        exp_t e;
        e.cyc = cyc + d; e.kind = kind; e.val = val; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic tick(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            wr_en = 1'b0;
        end
    endtask

    task automatic wr(logic sel, logic [15:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
    endtask

    // Monitor: sample after each edge and compare due expectations
    initial begin
        logic [15:0] obs[5];
        forever begin
            @(posedge clk);
            cyc++;
            #1;
            obs[0] = {13'd0, hs_clk_en_o};
            obs[1] = {13'd0, periph_stop_req_o};
            obs[2] = {12'd0, sg_clk_en_o};
            rd_sel = 1'b0;
            #1 obs[3] = rd_data;
            rd_sel = 1'b1;
            #1 obs[4] = rd_data;
            while (q.size() > 0 && q[0].cyc <= cyc) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (obs[e.kind] !== e.val) begin
                    bad++;
                    $display("FAIL %s kind=%0d cyc=%0d actual=%h expected=%h",
                             e.tag, e.kind, cyc, obs[e.kind], e.val);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Driver
    initial begin
        tick(3);
        rst_n = 1'b1;
        // R1 reset state
        push(1, 0, 16'h0007, "R1"); push(1, 1, 16'h0000, "R1");
        push(1, 2, 16'h000F, "R1"); push(1, 3, 16'h0000, "R1");
        push(1, 4, 16'h0000, "R1");
        tick(2);

        // Memory controller (index 0) full handshake: R2 R3 R4 R5
        wr(1'b0, 16'h0001);
        push(1, 3, 16'h0001, "R2"); push(1, 1, 16'h0000, "R2");
        push(2, 1, 16'h0001, "R2"); push(2, 0, 16'h0007, "R2");
        tick(4);
        periph_ack_i[0] = 1'b1;
        push(2, 0, 16'h0007, "R3"); push(3, 0, 16'h0006, "R3");
        push(3, 3, 16'h0003, "R4"); push(3, 1, 16'h0001, "R4");
        tick(5);
        wr(1'b0, 16'h0000);
        push(1, 0, 16'h0007, "R5"); push(1, 1, 16'h0000, "R5");
        push(1, 3, 16'h0000, "R5");
        tick(1);
        periph_ack_i[0] = 1'b0;
        tick(4);

        // Withdraw before acknowledge (index 1): R6
        wr(1'b0, 16'h0004);
        push(2, 1, 16'h0002, "R6");
        tick(3);
        wr(1'b0, 16'h0000);
        push(1, 1, 16'h0000, "R6"); push(1, 0, 16'h0007, "R6");
        push(4, 0, 16'h0007, "R6");
        tick(5);

        // Acknowledge without request, writes to acknowledge bits: R9
        periph_ack_i[1] = 1'b1;
        wr(1'b0, 16'h002A);
        push(1, 3, 16'h0000, "R9"); push(1, 1, 16'h0000, "R9");
        push(5, 0, 16'h0007, "R9"); push(5, 3, 16'h0000, "R9");
        tick(6);

        // Early acknowledge then request (index 1): R10
        wr(1'b0, 16'h0004);
        push(2, 1, 16'h0002, "R10"); push(2, 0, 16'h0007, "R10");
        push(3, 0, 16'h0005, "R10"); push(3, 3, 16'h000C, "R10");
        tick(4);
        wr(1'b0, 16'h0000);
        push(1, 0, 16'h0007, "R10");
        tick(1);
        periph_ack_i[1] = 1'b0;
        tick(4);

        // Gated handshake peripheral (index 2) requested: R7
        wr(1'b1, 16'h0004);
        push(1, 0, 16'h0003, "R7"); push(1, 4, 16'h0004, "R7");
        tick(2);
        wr(1'b0, 16'h0010);
        push(1, 3, 16'h0010, "R7"); push(1, 1, 16'h0000, "R7");
        push(2, 3, 16'h0030, "R7"); push(2, 1, 16'h0000, "R7");
        push(2, 0, 16'h0003, "R7");
        tick(3);
        wr(1'b1, 16'h0000);
        push(1, 0, 16'h0003, "R7"); push(1, 4, 16'h0000, "R7");
        push(1, 1, 16'h0000, "R7");
        tick(3);
        wr(1'b0, 16'h0000);
        push(1, 0, 16'h0007, "R7"); push(1, 3, 16'h0000, "R7");
        tick(3);

        // Simple gates: R8
        wr(1'b1, 16'h0050);
        push(1, 2, 16'h0005, "R8"); push(1, 0, 16'h0007, "R8");
        push(1, 4, 16'h0050, "R8");
        tick(2);
        wr(1'b1, 16'h0000);
        push(1, 2, 16'h000F, "R8");
        tick(3);

        // Overlapping handshakes on index 0 and 2: R11
        wr(1'b0, 16'h0011);
        push(2, 1, 16'h0005, "R11"); push(2, 0, 16'h0007, "R11");
        tick(3);
        periph_ack_i[2] = 1'b1;
        push(3, 0, 16'h0003, "R11"); push(3, 3, 16'h0031, "R11");
        tick(4);
        periph_ack_i[0] = 1'b1;
        push(2, 0, 16'h0003, "R11"); push(3, 0, 16'h0002, "R11");
        push(3, 3, 16'h0033, "R11");
        tick(4);
        wr(1'b0, 16'h0000);
        push(1, 0, 16'h0007, "R11"); push(1, 1, 16'h0000, "R11");
        tick(1);
        periph_ack_i = '0;
        tick(5);

        while (q.size() > 0) tick(1);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule